// File: doc/BRIEF.md
# External Bus Chip-Select Controller

This block sits between a processor core and an external memory bus. Every external access the core starts is mapped to one of four address areas, taken from the top two address bits. The block drives that area's active-low chip select for the whole access. It stretches the access by a number of wait cycles chosen per area, and tells the core when the access is busy and when it finishes.

A small configuration space sets three things. First, which of the four chip-select pins act as chip selects and which stay general ports. Second, how many wait cycles each area takes. Third, how wide the address bus is. A processor-wide override forces exactly one wait cycle on every area. An external ready input can lengthen an access that has wait cycles. Upper address lines beyond the chosen bus width report port function and are driven low. The width-select input picks an 8-bit or a 16-bit data bus.

Top module: `ext_cs_ctrl`

## Requirements
- R1: After reset, area-control register (address 0) holds 0x01. Only pin 0 acts as a chip select (`pin_cs_bus_o`=0001), all chip selects are high, and an access to area 0 takes two cycles.
- R2: Area-control bit i (bits 0..3) set to 0 makes pin i a port (`pin_cs_bus_o[i]`=0), and `cs_n_o[i]` stays high through accesses to area i.
- R3: An access to address A selects area A[19:18]. While it runs, only that area's `cs_n_o` bit is low, and every chip select is high while idle.
- R4: With area-control bit 4+i set to 1 and the override off, an access to area i lasts one cycle.
- R5: With area-control bit 4+i at 0 and the override off, the wait-count register (address 1) field [2i+1:2i] gives the wait cycles: 0→1, 1→2, 2→3, 3→3. An access lasts one cycle plus its wait cycles, and `acc_done_o` is high in its final cycle only.
- R6: Mode register (address 2) bit 2 set to 1 makes every access take exactly one wait cycle, whatever the area-control bits 4..7 say.
- R7: `rdy_i` low at the end of the last wait cycle extends the access by one more cycle. It is ignored in accesses that have no wait cycles.
- R8: A request raised while an access is busy is dropped: the running access keeps its area, address and length.
- R9: Mode bits [1:0] choose the address width: 00 gives 20 bits, 01 gives 16 bits, 11 gives 12 bits. The illegal 10 is taken as 20 bits. Lines above the width drive 0.
- R10: `pin_addr_bus_o[k]` reports line A(12+k) as bus function. Bits 0..3 are 1 at 16 or 20 bits, and bits 4..7 are 1 at 20 bits only.
- R11: `data_hi_en_o` is 1 (16-bit data bus) when `byte_i` is low, and 0 when `byte_i` is high.
- R12: An access uses the settings in force on its start cycle. A register write during the access changes only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Configuration write strobe |
| reg_addr | input | 2 | Configuration register select (0 area control, 1 wait count, 2 mode) |
| reg_wdata | input | 8 | Configuration write data |
| acc_req | input | 1 | Start an external access (taken when idle) |
| acc_addr | input | 20 | Access address |
| rdy_i | input | 1 | External ready, low to stretch |
| byte_i | input | 1 | High selects the 8-bit data bus |
| cs_n_o | output | 4 | Active-low chip selects |
| addr_o | output | 20 | Address bus narrowed to chosen width |
| acc_busy_o | output | 1 | Access in progress (core stalls) |
| acc_done_o | output | 1 | Final cycle of the access |
| pin_cs_bus_o | output | 4 | Chip-select pin is bus function (1) or port (0) |
| pin_addr_bus_o | output | 8 | Lines A12..A19 are bus function (1) or port (0) |
| data_hi_en_o | output | 1 | Upper data byte lines in use |

## Verification
The bench builds the block with its default parameters: a 20-bit address, four areas and a 12-bit fixed low field. With these values every width code and every wait encoding can be reached within a few short accesses. A behavioural model tracks the remaining length of each access and its chip-select state. It is compared on every clock, while directed runs cover ready stretching, requests that collide with a busy access, and configuration writes in the middle of an access.

// File: rtl/ecs_pkg.sv
package ecs_pkg;

    localparam int NAREA    = 4;
    localparam int AREA_W   = 2;
    localparam int WF_W     = 2;
    localparam int CNT_W    = 2;
    localparam int REG_W    = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BASE = 2'd1,
        ST_WAIT = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic [NAREA-1:0]      cs_en;
        logic [NAREA-1:0]      no_wait;
        logic [NAREA*WF_W-1:0] wfield;
        logic                  force1;
    } area_cfg_t;

    function automatic logic [CNT_W-1:0] wait_count(
        input logic            force1,
        input logic            no_wait,
        input logic [WF_W-1:0] fld
    );
        if (force1)         return CNT_W'(1);
        else if (no_wait)   return '0;
        else if (fld == '1) return CNT_W'(3);
        else                return fld + CNT_W'(1);
    endfunction

endpackage

// File: rtl/ecs_regs.sv
module ecs_regs
    import ecs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wdata,
    output area_cfg_t        cfg,
    output logic             nar16,
    output logic             nar12
);
    logic [REG_W-1:0] ctl_q;
    logic [REG_W-1:0] wf_q;
    logic [2:0]       mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= REG_W'(1);
            wf_q   <= '0;
            mode_q <= '0;
        end else if (we) begin
            case (addr)
                2'd0:    ctl_q  <= wdata;
                2'd1:    wf_q   <= wdata;
                2'd2:    mode_q <= wdata[2:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg.cs_en   = ctl_q[NAREA-1:0];
        cfg.no_wait = ctl_q[2*NAREA-1:NAREA];
        cfg.wfield  = wf_q;
        cfg.force1  = mode_q[2];
    end

    assign nar16 = mode_q[0];
    assign nar12 = mode_q[1];
endmodule

// File: rtl/ecs_seq.sv
module ecs_seq
    import ecs_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [AW-1:0]     req_addr,
    input  logic              rdy,
    input  area_cfg_t         cfg,
    output logic              busy,
    output logic              done,
    output logic [AREA_W-1:0] area_q,
    output logic              cs_on_q,
    output logic [AW-1:0]     addr_q
);
    seq_st_e           st_q;
    logic [CNT_W-1:0]  wait_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [AREA_W-1:0] area_c;
    logic [CNT_W-1:0]  wait_c;

    assign area_c = req_addr[AW-1 -: AREA_W];
    assign wait_c = wait_count(cfg.force1, cfg.no_wait[area_c],
                               cfg.wfield[area_c*WF_W +: WF_W]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            wait_q  <= '0;
            cnt_q   <= '0;
            area_q  <= '0;
            cs_on_q <= 1'b0;
            addr_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (req) begin
                    area_q  <= area_c;
                    addr_q  <= req_addr;
                    wait_q  <= wait_c;
                    cs_on_q <= cfg.cs_en[area_c];
                    st_q    <= ST_BASE;
                end
                ST_BASE: if (wait_q == '0) begin
                    st_q <= ST_IDLE;
                end else begin
                    cnt_q <= wait_q;
                    st_q  <= ST_WAIT;
                end
                ST_WAIT: if (cnt_q > CNT_W'(1)) begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end else if (rdy) begin
                    st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (st_q != ST_IDLE);
    assign done = ((st_q == ST_BASE) && (wait_q == '0)) ||
                  ((st_q == ST_WAIT) && (cnt_q == CNT_W'(1)) && rdy);
endmodule

// File: rtl/ecs_pinmux.sv
module ecs_pinmux
    import ecs_pkg::*;
#(
    parameter int AW     = 20,
    parameter int FIX_LO = 12,
    parameter int MID    = 4
) (
    input  logic              nar16,
    input  logic              nar12,
    input  logic              busy,
    input  logic              cs_on,
    input  logic [AREA_W-1:0] area,
    input  logic [AW-1:0]     addr_q,
    input  logic              byte_i,
    output logic [NAREA-1:0]  cs_n,
    output logic [AW-1:0]     addr_o,
    output logic [AW-FIX_LO-1:0] pin_addr_bus,
    output logic              data_hi_en
);
    localparam int UP = AW - FIX_LO;

    logic bus_mid;
    logic bus_top;

    assign bus_top = ~nar16;
    assign bus_mid = ~(nar16 & nar12);

    assign addr_o[FIX_LO-1:0] = addr_q[FIX_LO-1:0];

    for (genvar k = 0; k < UP; k++) begin : g_up
        if (k < MID) begin : g_mid
            assign pin_addr_bus[k] = bus_mid;
        end else begin : g_top
            assign pin_addr_bus[k] = bus_top;
        end
        assign addr_o[FIX_LO+k] = addr_q[FIX_LO+k] & pin_addr_bus[k];
    end

    for (genvar i = 0; i < NAREA; i++) begin : g_cs
        assign cs_n[i] = ~(busy && cs_on && (area == AREA_W'(i)));
    end

    assign data_hi_en = ~byte_i;
endmodule

// File: rtl/ext_cs_ctrl.sv
module ext_cs_ctrl
    import ecs_pkg::*;
#(
    parameter int AW     = 20,
    parameter int FIX_LO = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [1:0]           reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    input  logic                 acc_req,
    input  logic [AW-1:0]        acc_addr,
    input  logic                 rdy_i,
    input  logic                 byte_i,
    output logic [NAREA-1:0]     cs_n_o,
    output logic [AW-1:0]        addr_o,
    output logic                 acc_busy_o,
    output logic                 acc_done_o,
    output logic [NAREA-1:0]     pin_cs_bus_o,
    output logic [AW-FIX_LO-1:0] pin_addr_bus_o,
    output logic                 data_hi_en_o
);
    area_cfg_t         cfg;
    logic              nar16;
    logic              nar12;
    logic [AREA_W-1:0] area_q;
    logic              cs_on_q;
    logic [AW-1:0]     addr_q;

    ecs_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .cfg   (cfg),
        .nar16 (nar16),
        .nar12 (nar12)
    );

    ecs_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (acc_req),
        .req_addr (acc_addr),
        .rdy      (rdy_i),
        .cfg      (cfg),
        .busy     (acc_busy_o),
        .done     (acc_done_o),
        .area_q   (area_q),
        .cs_on_q  (cs_on_q),
        .addr_q   (addr_q)
    );

    ecs_pinmux #(.AW(AW), .FIX_LO(FIX_LO), .MID(4)) u_pinmux (
        .nar16        (nar16),
        .nar12        (nar12),
        .busy         (acc_busy_o),
        .cs_on        (cs_on_q),
        .area         (area_q),
        .addr_q       (addr_q),
        .byte_i       (byte_i),
        .cs_n         (cs_n_o),
        .addr_o       (addr_o),
        .pin_addr_bus (pin_addr_bus_o),
        .data_hi_en   (data_hi_en_o)
    );

    assign pin_cs_bus_o = cfg.cs_en;
endmodule

// File: rtl/ext_cs_ctrl_chk.sv
module ext_cs_ctrl_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst,
    input logic [3:0]    cs_n,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] addr,
    input logic          nar16,
    input logic          nar12
);
    p_cs_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    p_idle_cs_high_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cs_n == 4'hF));

    p_done_ends_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    p_busy_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    p_cs_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(cs_n));

    p_addr_narrow12_r9: assert property (@(posedge clk) disable iff (rst)
        (nar16 && nar12) |-> (addr[AW-1:12] == '0));

    p_addr_narrow16_r9: assert property (@(posedge clk) disable iff (rst)
        (nar16 && !nar12) |-> (addr[AW-1:16] == '0));
endmodule

bind ext_cs_ctrl ext_cs_ctrl_chk #(.AW(AW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .cs_n  (cs_n_o),
    .busy  (acc_busy_o),
    .done  (acc_done_o),
    .addr  (addr_o),
    .nar16 (nar16),
    .nar12 (nar12)
);

// File: tb/test_ext_cs_ctrl.sv
module test_ext_cs_ctrl;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic          acc_req = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic          rdy_i = 1'b1;
    logic          byte_i = 1'b0;
    logic [3:0]    cs_n_o;
    logic [AW-1:0] addr_o;
    logic          acc_busy_o;
    logic          acc_done_o;
    logic [3:0]    pin_cs_bus_o;
    logic [7:0]    pin_addr_bus_o;
    logic          data_hi_en_o;

    always #10 clk = ~clk;

    ext_cs_ctrl i_ext_cs_ctrl (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .acc_req(acc_req), .acc_addr(acc_addr),
        .rdy_i(rdy_i), .byte_i(byte_i), .cs_n_o(cs_n_o), .addr_o(addr_o),
        .acc_busy_o(acc_busy_o), .acc_done_o(acc_done_o),
        .pin_cs_bus_o(pin_cs_bus_o), .pin_addr_bus_o(pin_addr_bus_o),
        .data_hi_en_o(data_hi_en_o)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit started = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // behavioural reference model
    logic [7:0]    m_ctl, m_wf, m_mode;
    bit            m_active;
    int            m_left, m_w, m_area;
    bit            m_cson;
    logic [AW-1:0] m_addr;

    function automatic int model_wait(input int a);
        int f;
        if (m_mode[2]) return 1;
        if (m_ctl[4+a]) return 0;
        f = int'(m_wf[2*a +: 2]);
        return (f == 3) ? 3 : f + 1;
    endfunction

    function automatic int model_width();
        if (!m_mode[0]) return 20;
        return m_mode[1] ? 12 : 16;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ctl = 8'h01; m_wf = 8'h00; m_mode = 8'h00;
            m_active = 0; m_left = 0; m_w = 0; m_area = 0; m_cson = 0;
            m_addr = '0;
            started = 1'b1;
        end else begin
            if (m_active) begin
                if (m_left > 1) m_left--;
                else if (m_w == 0 || rdy_i) m_active = 0;
            end else if (acc_req) begin
                m_area   = int'(acc_addr[AW-1 -: 2]);
                m_addr   = acc_addr;
                m_w      = model_wait(m_area);
                m_left   = 1 + m_w;
                m_cson   = m_ctl[m_area];
                m_active = 1;
            end
            if (reg_we) begin
                case (reg_addr)
                    2'd0: m_ctl  = reg_wdata;
                    2'd1: m_wf   = reg_wdata;
                    2'd2: m_mode = {5'b0, reg_wdata[2:0]};
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (started && !rst) begin
            logic [3:0]    e_cs;
            logic [AW-1:0] e_addr;
            logic [7:0]    e_pa;
            int            wd;
            e_cs = 4'hF;
            if (m_active && m_cson) e_cs[m_area] = 1'b0;
            wd = model_width();
            e_addr = m_addr;
            for (int b = 12; b < AW; b++) if (b >= wd) e_addr[b] = 1'b0;
            e_pa = (wd == 20) ? 8'hFF : (wd == 16) ? 8'h0F : 8'h00;
            chk("R3", cs_n_o, e_cs, "cs_n_o");
            chk("R8", acc_busy_o, m_active, "busy");
            chk("R5", acc_done_o,
                m_active && m_left == 1 && (m_w == 0 || rdy_i), "done");
            chk("R9", addr_o, e_addr, "addr_o");
            chk("R2", pin_cs_bus_o, m_ctl[3:0], "pin_cs_bus_o");
            chk("R10", pin_addr_bus_o, e_pa, "pin_addr_bus_o");
            chk("R11", data_hi_en_o, !byte_i, "data_hi_en_o");
        end
    end

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_we = 1'b0;
    endtask

    // start an access, optionally stretch RDY, collide a request or write mid-access
    task automatic run_access(input logic [AW-1:0] a, input int exp_len,
                              input string tag, input int rdy_low,
                              input bit req2, input logic [AW-1:0] a2,
                              input bit wr_mid, input logic [1:0] wa,
                              input logic [7:0] wd);
        int len;
        @(posedge clk); #2;
        acc_req = 1'b1; acc_addr = a;
        if (rdy_low > 0) rdy_i = 1'b0;
        @(posedge clk); #2;
        acc_req = 1'b0;
        if (req2) begin acc_req = 1'b1; acc_addr = a2; end
        if (wr_mid) begin reg_we = 1'b1; reg_addr = wa; reg_wdata = wd; end
        len = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (!acc_busy_o) break;
            len++;
            #1;
            if (c == 1) begin acc_req = 1'b0; reg_we = 1'b0; end
            if (len >= rdy_low) rdy_i = 1'b1;
        end
        acc_req = 1'b0; reg_we = 1'b0; rdy_i = 1'b1;
        chk(tag, len, exp_len, "access length");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", pin_cs_bus_o, 4'b0001, "reset pin_cs_bus_o");
        chk("R1", cs_n_o, 4'hF, "reset cs_n_o");
        chk("R1", acc_busy_o, 1'b0, "reset busy");
        run_access(20'h00010, 2, "R1", 0, 0, '0, 0, 2'd0, 8'h0);
        // R2 area 1 disabled: cs stays high (model compare), length still 2
        run_access(20'h40020, 2, "R2", 0, 0, '0, 0, 2'd0, 8'h0);
        // R4 all enabled, no wait
        write_reg(2'd0, 8'hFF);
        for (int a = 0; a < 4; a++)
            run_access(AW'(a) << 18 | 20'h00123, 1, "R4", 0, 0, '0, 0, 2'd0, 8'h0);
        // R5 wait encodings
        write_reg(2'd0, 8'h0F);
        write_reg(2'd1, 8'hE4);
        run_access(20'h00001, 2, "R5", 0, 0, '0, 0, 2'd0, 8'h0);
        run_access(20'h40002, 3, "R5", 0, 0, '0, 0, 2'd0, 8'h0);
        run_access(20'h80003, 4, "R5", 0, 0, '0, 0, 2'd0, 8'h0);
        run_access(20'hC0004, 4, "R5", 0, 0, '0, 0, 2'd0, 8'h0);
        // R6 forced single wait
        write_reg(2'd2, 8'h04);
        run_access(20'hC0005, 2, "R6", 0, 0, '0, 0, 2'd0, 8'h0);
        write_reg(2'd0, 8'hFF);
        run_access(20'h40006, 2, "R6", 0, 0, '0, 0, 2'd0, 8'h0);
        write_reg(2'd2, 8'h00);
        // R7 RDY stretch and zero-wait ignore
        run_access(20'h40007, 1, "R7", 5, 0, '0, 0, 2'd0, 8'h0);
        write_reg(2'd0, 8'h0F);
        write_reg(2'd1, 8'h00);
        run_access(20'h00008, 5, "R7", 5, 0, '0, 0, 2'd0, 8'h0);
        // R8 colliding request dropped
        write_reg(2'd1, 8'hE4);
        run_access(20'hC0ABC, 4, "R8", 0, 1, 20'h00123, 0, 2'd0, 8'h0);
        // R12 mid-access write affects only later accesses
        run_access(20'h80055, 4, "R12", 0, 0, '0, 1, 2'd0, 8'hF0);
        run_access(20'h80056, 1, "R12", 0, 0, '0, 0, 2'd0, 8'h0);
        chk("R12", pin_cs_bus_o, 4'b0000, "pin_cs after write");
        // R9 / R10 widths
        write_reg(2'd0, 8'hFF);
        write_reg(2'd2, 8'h01);
        run_access(20'hFABCD, 1, "R9", 0, 0, '0, 0, 2'd0, 8'h0);
        @(negedge clk);
        chk("R9", addr_o, 20'h0ABCD, "16-bit address");
        chk("R10", pin_addr_bus_o, 8'h0F, "16-bit pins");
        write_reg(2'd2, 8'h03);
        @(negedge clk);
        chk("R9", addr_o, 20'h00BCD, "12-bit address");
        chk("R10", pin_addr_bus_o, 8'h00, "12-bit pins");
        write_reg(2'd2, 8'h02);
        @(negedge clk);
        chk("R9", addr_o, 20'hFABCD, "illegal code as 20-bit");
        // R11 data width
        #1 byte_i = 1'b1;
        @(negedge clk);
        chk("R11", data_hi_en_o, 1'b0, "byte high");
        #1 byte_i = 1'b0;
        @(negedge clk);
        chk("R11", data_hi_en_o, 1'b1, "byte low");
        repeat (3) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule